// File: doc/BRIEF.md
# Converter Result Monitor

This block sits after the decimation filter of a 24-bit sigma-delta converter and post-processes every conversion result. Each result is held in a data register guarded by a ready flag, so a result that software has not yet read is never overwritten. A conversion flag can be raised on every result, or only on every Nth result when result-count mode is on.

In parallel, the block computes the magnitude of each result. It compares that magnitude against a programmable threshold and tracks runs of exceeding results in an exceedance counter. Below-threshold results either decrement that counter or clear it. The block also adds the magnitudes into a saturating accumulator, which has a threshold of its own. Three sticky flags are each gated by a mask bit and ORed onto a single interrupt line. Configuration uses a write strobe with an address. State is read back through a combinational read port, and a read of the data address clears the ready flag.

Top module: `adc_result_monitor`

## Requirements
- R1: A result strobe with the ready flag (status bit 0) clear stores the result and sets ready. A read of address 0 returns the stored result, sign-extended to 32 bits when CTRL bit 0 is 1 (two's complement) and zero-extended when it is 0 (unipolar).
- R2: A result that arrives while ready is set, with no data read in the same cycle, leaves the stored result unchanged, and ready stays set.
- R3: A read of address 0 clears ready (status bit 0) and the conversion flag (status bit 1) on the next clock. A later result is then stored.
- R4: With CTRL bit 1 at 0, every result sets the conversion flag. With CTRL bit 1 at 1, the result counter (read address 4) increments on each result. The flag is set only by the result that makes the count equal to the target at write address 1, and the counter then returns to 0.
- R5: A write to CTRL (write address 0) resets the result counter and the exceedance counter to 0.
- R6: The magnitude of a result is the code itself in unipolar mode and its absolute value in two's-complement mode. The most negative code gives 0x7FFFFF. A result exceeds when its magnitude is at least T×256. T is bits 15:0 of the threshold at write address 2 in unipolar mode, and bits 14:0 in two's-complement mode.
- R7: The exceedance counter (read address 3) increments on each exceeding result and saturates at its maximum. On a non-exceeding result it decrements, but not below 0, when CTRL bit 2 is 0, and it clears when CTRL bit 2 is 1.
- R8: The exceedance flag (status bit 2) is set when an exceeding result leaves the counter at or above the limit at write address 3. It stays set until a 1 is written to bit 2 at write address 6.
- R9: The accumulator (read address 2) adds every magnitude and saturates at 0xFFFFFFFF. Any write to address 5 clears it to 0.
- R10: The accumulator flag (status bit 3) is set when the updated accumulator is at or above the 32-bit threshold at write address 4. It stays set until a 1 is written to bit 3 at write address 6.
- R11: The interrupt output is high exactly when at least one flag is set together with its mask bit: conversion flag with CTRL bit 3, exceedance flag with CTRL bit 4, accumulator flag with CTRL bit 5.
- R12: After reset, all flags, counters, the accumulator and the stored result are 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | DATA_W | Conversion result code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | BUS_W | Configuration write data |
| rd_en | input | 1 | Read strobe; clears ready when the data address is read |
| rd_addr | input | 3 | Read address |
| rd_data | output | BUS_W | Combinational read data |
| irq | output | 1 | Masked OR of the three flags |

## Verification
Every internal state is visible one clock after the result or write that changes it. The stored result, the two counters and the accumulator each appear at their own read addresses. Status bits show the flags, and the interrupt pin shows them again through the masks. An error in the ready guard shows at the next data read as a later value in place of the first one. An error in the counting shows as a count that is off by one, or as a conversion flag raised on the wrong result of a sequence. Long-horizon faults, such as a wrapping accumulator or a counter that underflows, only appear after a run of results. The directed scenarios therefore drive those runs all the way to the boundary.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      WA_CTRL      = 3'd0,
      WA_RCNT_TGT  = 3'd1,
      WA_THRESH    = 3'd2,
      WA_EXC_LIMIT = 3'd3,
      WA_ACC_TH    = 3'd4,
      WA_ACC_CLR   = 3'd5,
      WA_FLAG_CLR  = 3'd6
   } wr_addr_e;

   typedef enum logic [ADDR_W-1:0] {
      RA_DATA   = 3'd0,
      RA_STATUS = 3'd1,
      RA_ACC    = 3'd2,
      RA_EXC    = 3'd3,
      RA_RCNT   = 3'd4
   } rd_addr_e;

   // control register fields
   localparam int CTL_TWOS    = 0;
   localparam int CTL_CNT_EN  = 1;
   localparam int CTL_EXC_RST = 2;
   localparam int CTL_MASK_LO = 3;
   localparam int CTL_W       = 6;

   // status bit positions (also used by the flag-clear write)
   localparam int ST_READY = 0;
   localparam int ST_CONV  = 1;
   localparam int ST_EXC   = 2;
   localparam int ST_ACC   = 3;

   typedef struct packed {
      logic acc;
      logic exc;
      logic conv;
   } irq_vec_t;

endpackage

// File: rtl/adc_mon_latch.sv
module adc_mon_latch #(
   parameter int DATA_W = 24,
   parameter int RCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              rd_hit,
   input  logic              cnt_en,
   input  logic [RCNT_W-1:0] cnt_tgt,
   input  logic              cnt_clr,
   output logic [DATA_W-1:0] data_q,
   output logic              ready_q,
   output logic              conv_flag_q,
   output logic [RCNT_W-1:0] rcnt_q
);

   logic [RCNT_W-1:0] rcnt_inc;
   logic              cnt_match;
   logic              conv_hit;
   logic              take;

   assign rcnt_inc  = rcnt_q + 1'b1;
   assign cnt_match = (rcnt_inc == cnt_tgt);
   assign conv_hit  = res_valid && (!cnt_en || cnt_match);
   assign take      = res_valid && (!ready_q || rd_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
      end else if (take) begin
         data_q  <= res_data;
         ready_q <= 1'b1;
      end else if (rd_hit) begin
         ready_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt_q <= '0;
      end else if (cnt_clr) begin
         rcnt_q <= '0;
      end else if (res_valid && cnt_en) begin
         rcnt_q <= cnt_match ? '0 : rcnt_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_flag_q <= 1'b0;
      end else if (conv_hit) begin
         conv_flag_q <= 1'b1;
      end else if (rd_hit) begin
         conv_flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_mon_thresh.sv
module adc_mon_thresh #(
   parameter int DATA_W = 24,
   parameter int TH_W   = 16,
   parameter int EXC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              twos,
   input  logic              rst_mode,
   input  logic [TH_W-1:0]   thresh,
   input  logic [EXC_W-1:0]  limit,
   input  logic              cnt_clr,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] mag,
   output logic [EXC_W-1:0]  exc_cnt_q,
   output logic              exc_flag_q
);

   localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

   logic [TH_W-1:0]  th_eff;
   logic             above;
   logic [EXC_W-1:0] cnt_next;

   always_comb begin
      if (twos && res_data[DATA_W-1]) begin
         mag = (res_data == NEG_MIN) ? POS_MAX : (~res_data + 1'b1);
      end else begin
         mag = res_data;
      end
   end

   // top threshold bit is ignored in two's-complement mode
   assign th_eff = twos ? {1'b0, thresh[TH_W-2:0]} : thresh;
   assign above  = (mag[DATA_W-1 -: TH_W] >= th_eff);

   always_comb begin
      if (above) begin
         cnt_next = (exc_cnt_q == '1) ? exc_cnt_q : exc_cnt_q + 1'b1;
      end else if (rst_mode) begin
         cnt_next = '0;
      end else begin
         cnt_next = (exc_cnt_q == '0) ? '0 : exc_cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_cnt_q <= '0;
      end else if (cnt_clr) begin
         exc_cnt_q <= '0;
      end else if (res_valid) begin
         exc_cnt_q <= cnt_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_flag_q <= 1'b0;
      end else if (res_valid && !cnt_clr && above && (cnt_next >= limit)) begin
         exc_flag_q <= 1'b1;
      end else if (flag_clr) begin
         exc_flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_mon_accum.sv
module adc_mon_accum #(
   parameter int DATA_W  = 24,
   parameter int ACC_W   = 32,
   parameter bit ACC_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] mag,
   input  logic              acc_clr,
   input  logic [ACC_W-1:0]  acc_th,
   input  logic              flag_clr,
   output logic [ACC_W-1:0]  acc_q,
   output logic              acc_flag_q
);

   logic [ACC_W-1:0] acc_next;

   generate
      if (ACC_SAT) begin : g_sat
         logic [ACC_W:0] sum_w;
         assign sum_w    = {1'b0, acc_q} + {1'b0, ACC_W'(mag)};
         assign acc_next = sum_w[ACC_W] ? '1 : sum_w[ACC_W-1:0];
      end else begin : g_wrap
         assign acc_next = acc_q + ACC_W'(mag);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (acc_clr) begin
         acc_q <= '0;
      end else if (res_valid) begin
         acc_q <= acc_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_flag_q <= 1'b0;
      end else if (res_valid && !acc_clr && (acc_next >= acc_th)) begin
         acc_flag_q <= 1'b1;
      end else if (flag_clr) begin
         acc_flag_q <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_result_monitor.sv
module adc_result_monitor
   import adc_mon_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int TH_W    = 16,
   parameter int RCNT_W  = 16,
   parameter int EXC_W   = 16,
   parameter int ACC_W   = 32,
   parameter bit ACC_SAT = 1'b1,
   parameter int BUS_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BUS_W-1:0]  cfg_wdata,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BUS_W-1:0]  rd_data,
   output logic              irq
);

   generate
      if (TH_W < 2 || TH_W > DATA_W) begin : g_bad_th
         $error("TH_W must lie between 2 and DATA_W");
      end
      if (ACC_W < DATA_W) begin : g_bad_acc
         $error("ACC_W must not be narrower than DATA_W");
      end
      if (DATA_W > BUS_W || ACC_W > BUS_W || RCNT_W > BUS_W || EXC_W > BUS_W) begin : g_bad_bus
         $error("a register is wider than BUS_W");
      end
   endgenerate

   logic [CTL_W-1:0]  ctrl_q;
   logic [RCNT_W-1:0] rcnt_tgt_q;
   logic [TH_W-1:0]   thresh_q;
   logic [EXC_W-1:0]  limit_q;
   logic [ACC_W-1:0]  acc_th_q;

   logic ctrl_we, acc_clr_we, flag_clr_we, rd_data_hit;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] mag;
   logic              ready_q, conv_flag, exc_flag, acc_flag;
   logic [RCNT_W-1:0] rcnt_q;
   logic [EXC_W-1:0]  exc_cnt_q;
   logic [ACC_W-1:0]  acc_q;
   irq_vec_t          flags;

   assign ctrl_we     = cfg_we && (cfg_addr == WA_CTRL);
   assign acc_clr_we  = cfg_we && (cfg_addr == WA_ACC_CLR);
   assign flag_clr_we = cfg_we && (cfg_addr == WA_FLAG_CLR);
   assign rd_data_hit = rd_en && (rd_addr == RA_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         rcnt_tgt_q <= '0;
         thresh_q   <= '0;
         limit_q    <= '0;
         acc_th_q   <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == WA_CTRL)      ctrl_q     <= cfg_wdata[CTL_W-1:0];
         if (cfg_addr == WA_RCNT_TGT)  rcnt_tgt_q <= cfg_wdata[RCNT_W-1:0];
         if (cfg_addr == WA_THRESH)    thresh_q   <= cfg_wdata[TH_W-1:0];
         if (cfg_addr == WA_EXC_LIMIT) limit_q    <= cfg_wdata[EXC_W-1:0];
         if (cfg_addr == WA_ACC_TH)    acc_th_q   <= cfg_wdata[ACC_W-1:0];
      end
   end

   adc_mon_latch #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .res_valid   (res_valid),
      .res_data    (res_data),
      .rd_hit      (rd_data_hit),
      .cnt_en      (ctrl_q[CTL_CNT_EN]),
      .cnt_tgt     (rcnt_tgt_q),
      .cnt_clr     (ctrl_we),
      .data_q      (data_q),
      .ready_q     (ready_q),
      .conv_flag_q (conv_flag),
      .rcnt_q      (rcnt_q)
   );

   adc_mon_thresh #(.DATA_W(DATA_W), .TH_W(TH_W), .EXC_W(EXC_W)) u_thresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid),
      .res_data   (res_data),
      .twos       (ctrl_q[CTL_TWOS]),
      .rst_mode   (ctrl_q[CTL_EXC_RST]),
      .thresh     (thresh_q),
      .limit      (limit_q),
      .cnt_clr    (ctrl_we),
      .flag_clr   (flag_clr_we && cfg_wdata[ST_EXC]),
      .mag        (mag),
      .exc_cnt_q  (exc_cnt_q),
      .exc_flag_q (exc_flag)
   );

   adc_mon_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .ACC_SAT(ACC_SAT)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .res_valid  (res_valid),
      .mag        (mag),
      .acc_clr    (acc_clr_we),
      .acc_th     (acc_th_q),
      .flag_clr   (flag_clr_we && cfg_wdata[ST_ACC]),
      .acc_q      (acc_q),
      .acc_flag_q (acc_flag)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RA_DATA: begin
            if (ctrl_q[CTL_TWOS]) rd_data = BUS_W'($signed(data_q));
            else                  rd_data = BUS_W'(data_q);
         end
         RA_STATUS: begin
            rd_data[ST_READY] = ready_q;
            rd_data[ST_CONV]  = conv_flag;
            rd_data[ST_EXC]   = exc_flag;
            rd_data[ST_ACC]   = acc_flag;
         end
         RA_ACC:  rd_data = BUS_W'(acc_q);
         RA_EXC:  rd_data = BUS_W'(exc_cnt_q);
         RA_RCNT: rd_data = BUS_W'(rcnt_q);
         default: rd_data = '0;
      endcase
   end

   assign flags = '{acc: acc_flag, exc: exc_flag, conv: conv_flag};
   assign irq   = |(flags & ctrl_q[CTL_MASK_LO +: 3]);

endmodule

// File: rtl/adc_mon_checks.sv
module adc_mon_checks #(
   parameter int DATA_W  = 24,
   parameter int RCNT_W  = 16,
   parameter int EXC_W   = 16,
   parameter int ACC_W   = 32,
   parameter bit ACC_SAT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic              rd_data_hit,
   input logic              ctrl_we,
   input logic              acc_clr_we,
   input logic              ready_q,
   input logic [DATA_W-1:0] data_q,
   input logic [RCNT_W-1:0] rcnt_q,
   input logic [EXC_W-1:0]  exc_cnt_q,
   input logic [ACC_W-1:0]  acc_q,
   input logic [2:0]        irq_mask,
   input logic              irq
);

   AST_READY_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> ready_q); // R1

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && !rd_data_hit) |=> $stable(data_q)); // R2

   AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_hit && !res_valid) |=> !ready_q); // R3

   AST_RCNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> (rcnt_q == '0)); // R5

   AST_EXC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && !ctrl_we) |=> $stable(exc_cnt_q)); // R7

   AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == 3'b000) |-> !irq); // R11

   generate
      if (ACC_SAT) begin : g_sat_chk
         AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && !acc_clr_we) |=> (acc_q >= $past(acc_q))); // R9
      end
   endgenerate

endmodule

bind adc_result_monitor adc_mon_checks #(
   .DATA_W (DATA_W),
   .RCNT_W (RCNT_W),
   .EXC_W  (EXC_W),
   .ACC_W  (ACC_W),
   .ACC_SAT(ACC_SAT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .res_valid   (res_valid),
   .rd_data_hit (rd_data_hit),
   .ctrl_we     (ctrl_we),
   .acc_clr_we  (acc_clr_we),
   .ready_q     (ready_q),
   .data_q      (data_q),
   .rcnt_q      (rcnt_q),
   .exc_cnt_q   (exc_cnt_q),
   .acc_q       (acc_q),
   .irq_mask    (ctrl_q[5:3]),
   .irq         (irq)
);

// File: tb/adc_result_monitor_test.sv
module adc_result_monitor_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [23:0] res_data = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0;
   int errors = 0;

   adc_result_monitor uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .res_data  (res_data),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic [23:0] d);
      @(negedge clk);
      res_valid = 1'b1; res_data = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input string what,
                         input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, what, v, exp);
   endtask

   task automatic st_chk(input string req, input string what,
                         input int bitpos, input logic exp);
      logic [31:0] v;
      rd(3'd1, v);
      chk(req, what, {31'b0, v[bitpos]}, {31'b0, exp});
   endtask

   task automatic irq_chk(input string req, input string what, input logic exp);
      @(negedge clk);
      #1 chk(req, what, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic t_reset;
      rd_chk("R12", "status after reset", 3'd1, 32'h0);
      rd_chk("R12", "accumulator after reset", 3'd2, 32'h0);
      irq_chk("R12", "irq after reset", 1'b0);
      rd_chk("R12", "data after reset", 3'd0, 32'h0);
   endtask

   task automatic t_latch_ext;
      wr(3'd0, 32'h1);
      push(24'h800010);
      rd_chk("R1", "sign-extended data", 3'd0, 32'hFF800010);
      push(24'h123456);
      rd_chk("R1", "positive data", 3'd0, 32'h00123456);
      wr(3'd0, 32'h0);
      push(24'h800010);
      rd_chk("R1", "zero-extended data", 3'd0, 32'h00800010);
   endtask

   task automatic t_hold;
      push(24'h000111);
      push(24'h000222);
      st_chk("R2", "ready kept set", 0, 1'b1);
      rd_chk("R2", "first result kept", 3'd0, 32'h00000111);
      st_chk("R3", "ready cleared by read", 0, 1'b0);
      st_chk("R3", "conv flag cleared by read", 1, 1'b0);
      push(24'h000333);
      rd_chk("R3", "new result after clear", 3'd0, 32'h00000333);
   endtask

   task automatic t_count;
      wr(3'd1, 32'd3);
      wr(3'd0, 32'h2);
      push(24'h10);
      push(24'h20);
      st_chk("R4", "no conv flag before target", 1, 1'b0);
      rd_chk("R4", "result count two", 3'd4, 32'd2);
      push(24'h30);
      st_chk("R4", "conv flag at target", 1, 1'b1);
      rd_chk("R4", "count restarts", 3'd4, 32'd0);
      rd_chk("R4", "data read", 3'd0, 32'h10);
      push(24'h40);
      rd_chk("R4", "count one", 3'd4, 32'd1);
      wr(3'd0, 32'h2);
      rd_chk("R5", "count cleared by ctrl write", 3'd4, 32'd0);
      wr(3'd0, 32'h0);
      rd_chk("R4", "data read", 3'd0, 32'h40);
      push(24'h50);
      st_chk("R4", "conv flag every result", 1, 1'b1);
      rd_chk("R4", "data read", 3'd0, 32'h50);
   endtask

   task automatic t_thresh;
      wr(3'd0, 32'h5);
      wr(3'd2, 32'h8100);
      rd_chk("R5", "exceed count cleared by ctrl write", 3'd3, 32'd0);
      push(24'hFF0000);
      rd_chk("R6", "negative magnitude exceeds", 3'd3, 32'd1);
      push(24'h800000);
      rd_chk("R6", "most negative exceeds", 3'd3, 32'd2);
      push(24'hFF0001);
      rd_chk("R7", "reset mode clears", 3'd3, 32'd0);
      wr(3'd0, 32'h4);
      push(24'h80FFFF);
      rd_chk("R6", "unipolar uses bit 15", 3'd3, 32'd0);
      push(24'h810000);
      rd_chk("R6", "unipolar at threshold", 3'd3, 32'd1);
   endtask

   task automatic t_exc;
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0100);
      wr(3'd3, 32'd3);
      wr(3'd6, 32'h4);
      push(24'h020000);
      push(24'h020000);
      st_chk("R8", "no flag below limit", 2, 1'b0);
      push(24'h020000);
      st_chk("R8", "flag at limit", 2, 1'b1);
      rd_chk("R7", "count three", 3'd3, 32'd3);
      push(24'h000100);
      rd_chk("R7", "down mode decrements", 3'd3, 32'd2);
      st_chk("R8", "flag sticky", 2, 1'b1);
      wr(3'd6, 32'h4);
      st_chk("R8", "flag cleared by write", 2, 1'b0);
      push(24'h000100);
      push(24'h000100);
      push(24'h000100);
      rd_chk("R7", "down mode floors at zero", 3'd3, 32'd0);
   endtask

   task automatic t_accum;
      wr(3'd0, 32'h1);
      wr(3'd4, 32'h00300000);
      wr(3'd5, 32'h0);
      wr(3'd6, 32'h8);
      rd_chk("R9", "accumulator cleared", 3'd2, 32'h0);
      push(24'h100000);
      rd_chk("R9", "first add", 3'd2, 32'h00100000);
      push(24'hF00000);
      rd_chk("R9", "negative adds magnitude", 3'd2, 32'h00200000);
      st_chk("R10", "no flag below threshold", 3, 1'b0);
      push(24'h100000);
      st_chk("R10", "flag at threshold", 3, 1'b1);
      wr(3'd5, 32'h0);
      push(24'h800000);
      rd_chk("R6", "most negative saturates", 3'd2, 32'h007FFFFF);
      wr(3'd5, 32'h0);
      for (int i = 0; i < 520; i++) push(24'h800000);
      rd_chk("R9", "accumulator saturates", 3'd2, 32'hFFFFFFFF);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      wr(3'd4, 32'hFFFFFFFF);
      wr(3'd5, 32'h0);
      wr(3'd6, 32'hC);
      wr(3'd0, 32'h0);
      rd(3'd0, v);
      push(24'h000005);
      irq_chk("R11", "masked conv flag", 1'b0);
      wr(3'd0, 32'h08);
      irq_chk("R11", "conv flag unmasked", 1'b1);
      rd(3'd0, v);
      irq_chk("R11", "conv flag cleared", 1'b0);
      wr(3'd0, 32'h20);
      wr(3'd4, 32'h1);
      push(24'h000005);
      irq_chk("R11", "accumulator flag unmasked", 1'b1);
      wr(3'd6, 32'h8);
      irq_chk("R11", "accumulator flag cleared", 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch_ext();
      t_hold();
      t_count();
      t_thresh();
      t_exc();
      t_accum();
      t_irq();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule